// File: doc/BRIEF.md
# Virtual Wire Event Interrupt Controller

This block turns parallel virtual-wire event levels into latched interrupt causes. The levels arrive already decoded, grouped into banks of 32 bits. Each bit selects how it triggers: on a rising edge, on a falling edge, on any change, or while the level is high. The bit also has its own enable. A bit that triggers while enabled sets its status flag. The flag stays set until software writes a one to that bit position.

Each bank also drives one bit of a shared summary register, so a handler can see which bank needs service. A single registered interrupt line is high while any bank holds a status bit that is also enabled. Software reaches all registers through a simple 32-bit word-addressed bus. A read returns its data one cycle after the request.

Top module: `vw_event_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The three trigger-code registers and the enable register of each bank read back the last value written. Bank k (k from 0) sits at word base 8*(k+1). The word offsets are: code bit 0 at +0, code bit 1 at +1, code bit 2 at +2, enable at +3, synchronized level at +4, status at +5. The summary register is at word 0. Unmapped words read 0.
- R3: The 3-bit code of a bit is {code2,code1,code0}. Code 001 sets status on a 0-to-1 change of the synchronized level.
- R4: Code 000 sets status on a 1-to-0 change.
- R5: Code 100 sets status on any change of level.
- R6: Code 010 sets status in every cycle the level is high. A clear while the level stays high is therefore undone.
- R7: Codes 011, 101, 110 and 111 never set status.
- R8: A bit whose enable bit is 0 never sets its status bit.
- R9: Writing the status word clears each bit written as 1 and leaves bits written as 0 unchanged.
- R10: If a trigger and a clear of the same status bit fall in the same cycle, the bit stays set.
- R11: The level word returns the event inputs after a two-stage synchronizer.
- R12: Summary bit k is set in every cycle that bank k captures an event. Writing 1 to a summary bit clears it, and a capture in the same cycle wins.
- R13: `irq` is high one cycle after any bank has a bit that is set in both status and enable. Clearing an enable bit drops its part of `irq` but keeps its status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_lvl | input | NBANK*DW | Event levels, bank k in bits [k*DW +: DW] |
| bus_sel | input | 1 | Bus request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after a read |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with its defaults: two banks of 32 bits and a 5-bit word address. With these values both bank pages and the summary word are reachable. Every one of the eight trigger codes can appear on some bit at the same time. The bank-to-summary mapping is exercised across more than one bank. Random trigger codes, enables, level flips and clear masks run against a bench model. Directed cases hit set-over-clear on the same cycle, level-high re-assertion and enable gating of `irq`.

// File: rtl/vwi_pkg.sv
package vwi_pkg;
  localparam int OFF_C0   = 0;
  localparam int OFF_C1   = 1;
  localparam int OFF_C2   = 2;
  localparam int OFF_EN   = 3;
  localparam int OFF_LVL  = 4;
  localparam int OFF_STAT = 5;

  // trigger codes as {code2,code1,code0}
  localparam logic [2:0] TRIG_FALL = 3'b000;
  localparam logic [2:0] TRIG_RISE = 3'b001;
  localparam logic [2:0] TRIG_HIGH = 3'b010;
  localparam logic [2:0] TRIG_ANY  = 3'b100;

  function automatic logic trig_hit(logic [2:0] code, logic prev, logic cur);
    case (code)
      TRIG_FALL: trig_hit = prev & ~cur;
      TRIG_RISE: trig_hit = ~prev & cur;
      TRIG_HIGH: trig_hit = cur;
      TRIG_ANY:  trig_hit = prev ^ cur;
      default:   trig_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/vwi_sync.sv
module vwi_sync #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic [DW-1:0] q_prev
);
  logic [DW-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/vwi_bank.sv
module vwi_bank
  import vwi_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] lvl_raw,
  input  logic          wr_en,
  input  logic [2:0]    wr_off,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] c0_q,
  output logic [DW-1:0] c1_q,
  output logic [DW-1:0] c2_q,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] lvl_q,
  output logic [DW-1:0] stat_q,
  output logic          cap_any
);
  logic [DW-1:0] lvl_prev;
  logic [DW-1:0] cap;
  logic [DW-1:0] clr;

  vwi_sync #(.DW(DW)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .d      (lvl_raw),
    .q      (lvl_q),
    .q_prev (lvl_prev)
  );

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign cap[i] = en_q[i] & trig_hit({c2_q[i], c1_q[i], c0_q[i]}, lvl_prev[i], lvl_q[i]);
  end

  assign cap_any = |cap;
  assign clr     = (wr_en && wr_off == 3'(OFF_STAT)) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      c0_q   <= '0;
      c1_q   <= '0;
      c2_q   <= '0;
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en) begin
        case (wr_off)
          3'(OFF_C0): c0_q <= wr_data;
          3'(OFF_C1): c1_q <= wr_data;
          3'(OFF_C2): c2_q <= wr_data;
          3'(OFF_EN): en_q <= wr_data;
          default: ;
        endcase
      end
      stat_q <= (stat_q & ~clr) | cap;
    end
  end
endmodule

// File: rtl/vw_event_irq_ctrl.sv
module vw_event_irq_ctrl
  import vwi_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NBANK  = 2,
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NBANK*DW-1:0] evt_lvl,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                irq
);
  localparam int PAGE_W = ADDR_W - 3;

  logic [NBANK-1:0][DW-1:0] c0_v, c1_v, c2_v, en_v, lvl_v, stat_v;
  logic [NBANK-1:0]         cap_v;
  logic [NBANK-1:0]         bank_wr;
  logic [NBANK-1:0]         sum_q;
  logic [NBANK-1:0]         sum_clr;
  logic [DW-1:0]            rd_n;
  logic                     irq_n;
  logic [PAGE_W-1:0]        page;

  assign page = bus_addr[ADDR_W-1:3];

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    assign bank_wr[k] = bus_sel & bus_wr & (page == PAGE_W'(k + 1));

    vwi_bank #(.DW(DW)) bank_i (
      .clk     (clk),
      .rst     (rst),
      .lvl_raw (evt_lvl[k*DW +: DW]),
      .wr_en   (bank_wr[k]),
      .wr_off  (bus_addr[2:0]),
      .wr_data (bus_wdata),
      .c0_q    (c0_v[k]),
      .c1_q    (c1_v[k]),
      .c2_q    (c2_v[k]),
      .en_q    (en_v[k]),
      .lvl_q   (lvl_v[k]),
      .stat_q  (stat_v[k]),
      .cap_any (cap_v[k])
    );
  end

  assign sum_clr = (bus_sel && bus_wr && bus_addr == '0) ? bus_wdata[NBANK-1:0] : '0;

  always_comb begin
    rd_n  = '0;
    irq_n = 1'b0;
    if (bus_addr == '0) rd_n = DW'(sum_q);
    for (int k = 0; k < NBANK; k++) begin
      irq_n = irq_n | (|(stat_v[k] & en_v[k]));
      if (page == PAGE_W'(k + 1)) begin
        case (bus_addr[2:0])
          3'(OFF_C0):   rd_n = c0_v[k];
          3'(OFF_C1):   rd_n = c1_v[k];
          3'(OFF_C2):   rd_n = c2_v[k];
          3'(OFF_EN):   rd_n = en_v[k];
          3'(OFF_LVL):  rd_n = lvl_v[k];
          3'(OFF_STAT): rd_n = stat_v[k];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q     <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      sum_q <= (sum_q & ~sum_clr) | cap_v;
      irq   <= irq_n;
      if (bus_sel && !bus_wr) bus_rdata <= rd_n;
    end
  end
endmodule

// File: rtl/vwi_chk.sv
module vwi_chk #(
  parameter int DW     = 32,
  parameter int NBANK  = 2,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input logic [DW-1:0]     st0,
  input logic [DW-1:0]     en0,
  input logic [DW-1:0]     st1,
  input logic [DW-1:0]     en1,
  input logic [NBANK-1:0]  sum
);
  localparam logic [ADDR_W-1:0] ST0_A = ADDR_W'(8 + 5);
  localparam logic [ADDR_W-1:0] ST1_A = ADDR_W'(16 + 5);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (st0 == '0 && st1 == '0 && !irq && sum == '0));

  // R8
  set_needs_enable0_chk: assert property (@(posedge clk) disable iff (rst)
    ((st0 & ~$past(st0) & ~$past(en0)) == '0));

  // R8
  set_needs_enable1_chk: assert property (@(posedge clk) disable iff (rst)
    ((st1 & ~$past(st1) & ~$past(en1)) == '0));

  // R9
  clear_needs_write0_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr && bus_addr == ST0_A) |=> (($past(st0) & ~st0) == '0));

  // R9
  clear_needs_write1_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr && bus_addr == ST1_A) |=> (($past(st1) & ~st1) == '0));

  // R12
  sum_clear_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr && bus_addr == '0) |=> (($past(sum) & ~sum) == '0));

  // R13
  irq_follows_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|(st0 & en0) || |(st1 & en1)) |=> irq);

  // R13
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|(st0 & en0)) && !(|(st1 & en1))) |=> !irq);
endmodule

bind vw_event_irq_ctrl vwi_chk #(.DW(DW), .NBANK(NBANK), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .irq      (irq),
  .st0      (stat_v[0]),
  .en0      (en_v[0]),
  .st1      (stat_v[1]),
  .en1      (en_v[1]),
  .sum      (sum_q)
);

// File: tb/vw_event_irq_ctrl_tb_top.sv
module vw_event_irq_ctrl_tb_top;
  localparam int DW = 32;
  localparam int NB = 2;
  localparam int AW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NB*DW-1:0] evt_lvl = '0;
  logic            bus_sel = 1'b0;
  logic            bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic            irq;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m_c0[NB], m_c1[NB], m_c2[NB], m_en[NB], m_lvl[NB], m_st[NB];
  logic [NB-1:0] m_sum;

  always #10 clk = ~clk;

  vw_event_irq_ctrl #(.DW(DW), .NBANK(NB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .evt_lvl(evt_lvl), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic m_hit(logic [2:0] code, logic p, logic c);
    case (code)
      3'b000: return p & ~c;
      3'b001: return ~p & c;
      3'b010: return c;
      3'b100: return p ^ c;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [AW-1:0] a_of(int b, int off);
    return AW'(8 * (b + 1) + off);
  endfunction

  function automatic logic m_irq();
    logic r = 1'b0;
    for (int b = 0; b < NB; b++) r = r | (|(m_st[b] & m_en[b]));
    return r;
  endfunction

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // level-high bits that are enabled keep setting status and summary
  task automatic refresh();
    for (int b = 0; b < NB; b++) begin
      logic [DW-1:0] h;
      h = m_en[b] & ~m_c2[b] & m_c1[b] & ~m_c0[b] & m_lvl[b];
      m_st[b] = m_st[b] | h;
      if (h != '0) m_sum[b] = 1'b1;
    end
  endtask

  task automatic cfg(int b, int off, logic [DW-1:0] d);
    bus_write(a_of(b, off), d);
    case (off)
      0: m_c0[b] = d;
      1: m_c1[b] = d;
      2: m_c2[b] = d;
      3: m_en[b] = d;
      default: ;
    endcase
    refresh();
  endtask

  task automatic clr_st(int b, logic [DW-1:0] m);
    bus_write(a_of(b, 5), m);
    m_st[b] = m_st[b] & ~m;
    refresh();
  endtask

  task automatic clr_sum(logic [NB-1:0] m);
    bus_write('0, DW'(m));
    m_sum = m_sum & ~m;
    refresh();
  endtask

  task automatic set_lvl(logic [DW-1:0] n0, logic [DW-1:0] n1);
    logic [DW-1:0] nv[NB];
    nv[0] = n0; nv[1] = n1;
    for (int b = 0; b < NB; b++) begin
      logic any = 1'b0;
      for (int i = 0; i < DW; i++) begin
        if (m_en[b][i] && m_hit({m_c2[b][i], m_c1[b][i], m_c0[b][i]}, m_lvl[b][i], nv[b][i])) begin
          m_st[b][i] = 1'b1;
          any = 1'b1;
        end
      end
      if (any) m_sum[b] = 1'b1;
      m_lvl[b] = nv[b];
    end
    @(negedge clk);
    evt_lvl = {n1, n0};
    repeat (5) @(negedge clk);
  endtask

  task automatic verify(string tag);
    logic [DW-1:0] d;
    for (int b = 0; b < NB; b++) begin
      bus_read(a_of(b, 5), d);
      chk({tag, " status"}, d, m_st[b]);
      bus_read(a_of(b, 4), d);
      chk("R11 level", d, m_lvl[b]);
    end
    bus_read('0, d);
    chk("R12 summary", d, DW'(m_sum));
    @(negedge clk);
    chk("R13 irq", DW'(irq), DW'(m_irq()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd20251));
    for (int b = 0; b < NB; b++) begin
      m_c0[b] = '0; m_c1[b] = '0; m_c2[b] = '0; m_en[b] = '0; m_lvl[b] = '0; m_st[b] = '0;
    end
    m_sum = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    for (int b = 0; b < NB; b++)
      for (int off = 0; off < 6; off++) begin
        bus_read(a_of(b, off), d);
        chk("R1 reset reg", d, '0);
      end
    bus_read('0, d);
    chk("R1 reset summary", d, '0);
    chk("R1 reset irq", DW'(irq), '0);

    // R2 readback and unmapped word
    cfg(1, 0, 32'hA5A5_0F0F);
    bus_read(a_of(1, 0), d);
    chk("R2 code0 readback", d, 32'hA5A5_0F0F);
    cfg(1, 3, 32'h1234_5678);
    bus_read(a_of(1, 3), d);
    chk("R2 enable readback", d, 32'h1234_5678);
    bus_read(AW'(7), d);
    chk("R2 unmapped", d, '0);
    cfg(1, 0, '0); cfg(1, 3, '0);

    // directed codes on bank 0: bit0 rise, bit1 fall, bit2 any, bit3 high, bit4 code 111
    cfg(0, 0, 32'h0000_0011);
    cfg(0, 1, 32'h0000_0018);
    cfg(0, 2, 32'h0000_0014);
    cfg(0, 3, 32'h0000_001F);
    set_lvl(32'h0000_001F, '0);
    bus_read(a_of(0, 5), d);
    chk("R3 R5 R6 R7 rise", d, 32'h0000_000D);
    verify("R3");
    clr_st(0, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    bus_read(a_of(0, 5), d);
    chk("R6 R9 high reasserts", d, 32'h0000_0008);
    set_lvl('0, '0);
    bus_read(a_of(0, 5), d);
    chk("R4 R5 fall", d, 32'h0000_000E);
    clr_st(0, 32'h0000_0002);
    bus_read(a_of(0, 5), d);
    chk("R9 partial clear", d, 32'h0000_000C);
    verify("R9");

    // R13 enable gates irq but keeps status
    cfg(0, 3, '0);
    repeat (2) @(negedge clk);
    chk("R13 irq gated", DW'(irq), '0);
    bus_read(a_of(0, 5), d);
    chk("R13 status kept", d, 32'h0000_000C);
    clr_st(0, 32'hFFFF_FFFF);
    clr_sum('1);

    // R8 disabled bit ignores edges
    set_lvl(32'h0000_0004, '0);
    bus_read(a_of(0, 5), d);
    chk("R8 disabled", d, '0);

    // R10 set wins over clear: bit2 dual-edge, enabled
    cfg(0, 3, 32'h0000_0004);
    set_lvl('0, '0);
    @(negedge clk);
    evt_lvl[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a_of(0, 5); bus_wdata = 32'h0000_0004;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    m_lvl[0][2] = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(a_of(0, 5), d);
    chk("R10 set wins", d, 32'h0000_0004);
    verify("R10");

    // random phase
    for (int it = 0; it < 160; it++) begin
      int b;
      int op;
      b = int'($urandom % NB);
      op = int'($urandom % 4);
      case (op)
        0: begin
          cfg(b, 0, $urandom);
          cfg(b, 1, $urandom & $urandom);
          cfg(b, 2, $urandom & $urandom);
          cfg(b, 3, $urandom);
        end
        1: set_lvl(m_lvl[0] ^ ($urandom & $urandom), m_lvl[1] ^ ($urandom & $urandom));
        2: clr_st(b, $urandom);
        default: clr_sum(NB'($urandom));
      endcase
      if (op == 1 || (it % 4) == 0) verify("R3 R4 R5 R6 R7 R8 R12 random");
    end
    verify("R9 final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule